// File: doc/BRIEF.md
# Tagged Transfer Command Ordering Queue

This block sits in front of a DMA engine and holds up to sixteen transfer commands that are waiting to start. Each command carries a direction, a 5-bit tag group, a byte count and two optional ordering modifiers. The block picks the next command the engine may start and offers it on a ready/valid issue port. Commands in different tag groups pass one another freely. Within a group, a fence holds back only the fenced command, while a barrier also holds back every later command of that group. A separate drain marker holds back every later command of every group until all earlier work has finished.

The engine reports each finished transfer by its tag alone. From these reports the block keeps, for each group, a count of commands that were accepted but have not finished. It also keeps a count of commands that were issued but have not finished. A 32-bit status vector shows which groups still have outstanding work. Commands with an illegal byte count are rejected at the door and raise a sticky flag. Completion reports that cannot match an issued command are discarded and raise a second sticky flag.

Top module: `dma_cmd_order`

## Requirements
- R1: A command is accepted on a cycle where `enq_valid_i` and `enq_ready_o` are both high. `enq_ready_o` is low while 16 commands are held. It is also low for a transfer whose tag group already has 63 outstanding commands.
- R2: A byte count is legal when it is nonzero, a multiple of 16 and at most 16384. An accepted transfer with any other count is consumed but not queued, and `size_err_o` rises on the next edge and stays high until reset. The size of a drain marker is ignored.
- R3: The block offers at most one command per cycle, always the oldest eligible one. `iss_dir_o` (0 = get into local memory, 1 = put to system memory), `iss_tag_o` and `iss_size_o` carry the values given at enqueue. A command accepted at an edge can be offered in the cycle that follows.
- R4: A command with no modifier is eligible as soon as no older barrier of its group and no older drain marker is queued. Completions are not needed.
- R5: A fenced command (`enq_fence_i`) waits until no older command of its group is queued and no command of its group is issued and unfinished. Younger unmodified commands of the same group may issue ahead of it.
- R6: A barrier command (`enq_barrier_i`) waits the way a fenced command does. Every younger command of its group is also held until the barrier command has issued. Other groups are not affected.
- R7: A drain marker (`enq_qbar_i` = 1) holds back every younger command of every group. It leaves the queue without being offered one cycle after it is the oldest entry and no group has an issued, unfinished command.
- R8: Once `iss_valid_o` is high it stays high until `iss_ready_i` takes a command. The offered command may change to an older one that has just become eligible.
- R9: `tag_busy_o[g]` is high while group g has commands that were accepted but not yet reported finished. The bit updates on the edge that accepts the command or the completion.
- R10: A completion whose tag has no issued, unfinished command is ignored. `cpl_err_o` rises on the next edge and stays high until reset.
- R11: After reset the queue is empty, `iss_valid_o` is low, `tag_busy_o` is zero, both error flags are low and `enq_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enq_valid_i | input | 1 | Command offered |
| enq_ready_o | output | 1 | Command can be accepted |
| enq_qbar_i | input | 1 | Command is a drain marker, not a transfer |
| enq_dir_i | input | 1 | Direction: 0 get, 1 put |
| enq_tag_i | input | 5 | Tag group |
| enq_size_i | input | 15 | Byte count |
| enq_fence_i | input | 1 | Fence modifier |
| enq_barrier_i | input | 1 | Barrier modifier |
| iss_valid_o | output | 1 | A command is offered to the engine |
| iss_ready_i | input | 1 | Engine takes the offered command |
| iss_dir_o | output | 1 | Direction of offered command |
| iss_tag_o | output | 5 | Tag group of offered command |
| iss_size_o | output | 15 | Byte count of offered command |
| cpl_valid_i | input | 1 | Completion report |
| cpl_tag_i | input | 5 | Tag of finished command |
| tag_busy_o | output | 32 | Per-group outstanding work |
| size_err_o | output | 1 | Sticky illegal-size flag |
| cpl_err_o | output | 1 | Sticky unmatched-completion flag |

## Verification
The assertions check on every cycle that an offer is held until taken and that only legal sizes ever reach the issue port. They also check that a fenced or barrier command never issues while its group has work in flight, that a busy bit covers any offered tag, that the in-flight count never exceeds the outstanding count, and that both error flags stay set. Which command is chosen depends on queue age and on what completed earlier, so the oldest-first choice can only be shown by the bench's scenarios. The same holds for a younger command passing a fence, for the hold behind a barrier and for the drain marker's release one cycle after the last completion. A behavioural model run beside the design compares every output on every clock, through directed ordering cases and a long random mix of a few crowded tag groups.

// File: rtl/dma_ord_pkg.sv
package dma_ord_pkg;
  localparam int TAG_W     = 5;
  localparam int NUM_TAGS  = 1 << TAG_W;
  localparam int SIZE_W    = 15;
  localparam int SIZE_MAX  = 16384;
  localparam int SIZE_GRAN = 16;

  typedef struct packed {
    logic              qbar;
    logic              dir;
    logic [TAG_W-1:0]  tag;
    logic [SIZE_W-1:0] size;
    logic              fence;
    logic              barrier;
  } cmd_t;
endpackage

// File: rtl/dma_ord_queue.sv
// Age-ordered store: slot 0 is oldest; removal compacts younger slots down.
module dma_ord_queue import dma_ord_pkg::*; #(
  parameter  int DEPTH  = 16,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int QCNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  cmd_t              push_cmd_i,
  input  logic              pop_i,
  input  logic [IDX_W-1:0]  pop_idx_i,
  output cmd_t              ent_o [DEPTH],
  output logic [QCNT_W-1:0] count_o,
  output logic              full_o
);
  cmd_t              ent_q [DEPTH];
  cmd_t              ent_d [DEPTH];
  logic [QCNT_W-1:0] count_q;
  logic [QCNT_W-1:0] base;

  assign base = count_q - QCNT_W'(pop_i);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    cmd_t src;
    if (i < DEPTH - 1) begin : g_shift
      assign src = ent_q[i+1];
    end else begin : g_last
      assign src = '0;
    end
    always_comb begin
      ent_d[i] = ent_q[i];
      if (pop_i && (IDX_W'(i) >= pop_idx_i)) ent_d[i] = src;
      if (push_i && (base == QCNT_W'(i)))    ent_d[i] = push_cmd_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      count_q <= count_q - QCNT_W'(pop_i) + QCNT_W'(push_i);
      ent_q   <= ent_d;
    end
  end

  assign ent_o   = ent_q;
  assign count_o = count_q;
  assign full_o  = (count_q == QCNT_W'(DEPTH));

  assert_no_overflow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> !full_o);
  assert_count_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= QCNT_W'(DEPTH));
  assert_pop_live_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (QCNT_W'(pop_idx_i) < count_q));
endmodule

// File: rtl/dma_ord_select.sv
// Eligibility per slot and oldest-first pick; drain marker retire at head.
module dma_ord_select import dma_ord_pkg::*; #(
  parameter  int DEPTH  = 16,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int QCNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  cmd_t                ent_i [DEPTH],
  input  logic [QCNT_W-1:0]   count_i,
  input  logic [NUM_TAGS-1:0] fly_zero_i,
  output logic                valid_o,
  output logic [IDX_W-1:0]    idx_o,
  output logic                retire_o
);
  logic [DEPTH-1:0] elig;

  for (genvar i = 0; i < DEPTH; i++) begin : g_elig
    logic qb_old, bar_old, tag_old, live, ordered;
    always_comb begin
      qb_old  = 1'b0;
      bar_old = 1'b0;
      tag_old = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (ent_i[j].qbar) qb_old = 1'b1;
        else if (ent_i[j].tag == ent_i[i].tag) begin
          tag_old = 1'b1;
          if (ent_i[j].barrier) bar_old = 1'b1;
        end
      end
    end
    assign live    = QCNT_W'(i) < count_i;
    assign ordered = ent_i[i].fence || ent_i[i].barrier;
    assign elig[i] = live && !ent_i[i].qbar && !qb_old && !bar_old &&
                     (!ordered || (!tag_old && fly_zero_i[ent_i[i].tag]));
  end

  always_comb begin
    idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) if (elig[i]) idx_o = IDX_W'(i);
  end
  assign valid_o  = |elig;
  assign retire_o = (count_i != '0) && ent_i[0].qbar && (&fly_zero_i);

  assert_qbar_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o |-> !valid_o);
endmodule

// File: rtl/dma_ord_tags.sv
// Per-group outstanding (enqueue..completion) and in-flight (issue..completion) counts.
module dma_ord_tags import dma_ord_pkg::*; #(
  parameter int OUT_W = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enq_inc_i,
  input  logic [TAG_W-1:0]    enq_tag_i,
  input  logic                iss_inc_i,
  input  logic [TAG_W-1:0]    iss_tag_i,
  input  logic                cpl_valid_i,
  input  logic [TAG_W-1:0]    cpl_tag_i,
  output logic [NUM_TAGS-1:0] busy_o,
  output logic [NUM_TAGS-1:0] fly_zero_o,
  output logic [NUM_TAGS-1:0] sat_o,
  output logic                cpl_bad_o
);
  logic [NUM_TAGS-1:0] fz;

  for (genvar g = 0; g < NUM_TAGS; g++) begin : g_tag
    logic [OUT_W-1:0] out_q, fly_q;
    logic hit_enq, hit_iss, hit_cpl;
    assign hit_enq = enq_inc_i && (enq_tag_i == TAG_W'(g));
    assign hit_iss = iss_inc_i && (iss_tag_i == TAG_W'(g));
    assign hit_cpl = cpl_valid_i && (cpl_tag_i == TAG_W'(g)) && (fly_q != '0);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        out_q <= '0;
        fly_q <= '0;
      end else begin
        out_q <= out_q + OUT_W'(hit_enq) - OUT_W'(hit_cpl);
        fly_q <= fly_q + OUT_W'(hit_iss) - OUT_W'(hit_cpl);
      end
    end
    assign fz[g]     = (fly_q == '0);
    assign busy_o[g] = (out_q != '0);
    assign sat_o[g]  = &out_q;

    assert_fly_within_out_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fly_q <= out_q);
  end

  assign fly_zero_o = fz;
  assign cpl_bad_o  = cpl_valid_i && fz[cpl_tag_i];
endmodule

// File: rtl/dma_cmd_order.sv
module dma_cmd_order import dma_ord_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int OUT_W = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enq_valid_i,
  output logic                enq_ready_o,
  input  logic                enq_qbar_i,
  input  logic                enq_dir_i,
  input  logic [TAG_W-1:0]    enq_tag_i,
  input  logic [SIZE_W-1:0]   enq_size_i,
  input  logic                enq_fence_i,
  input  logic                enq_barrier_i,
  output logic                iss_valid_o,
  input  logic                iss_ready_i,
  output logic                iss_dir_o,
  output logic [TAG_W-1:0]    iss_tag_o,
  output logic [SIZE_W-1:0]   iss_size_o,
  input  logic                cpl_valid_i,
  input  logic [TAG_W-1:0]    cpl_tag_i,
  output logic [NUM_TAGS-1:0] tag_busy_o,
  output logic                size_err_o,
  output logic                cpl_err_o
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int QCNT_W = $clog2(DEPTH + 1);
  localparam int GRAN_W = $clog2(SIZE_GRAN);

  cmd_t                ent [DEPTH];
  cmd_t                new_cmd;
  logic [QCNT_W-1:0]   count;
  logic                full, size_ok, enq_fire, push, enq_inc;
  logic                iss_fire, retire, pop, cpl_bad;
  logic [IDX_W-1:0]    sel_idx, pop_idx;
  logic [NUM_TAGS-1:0] fly_zero, sat;
  logic                size_err_q, cpl_err_q;

  assign size_ok = (enq_size_i[GRAN_W-1:0] == '0) && (enq_size_i != '0) &&
                   (enq_size_i <= SIZE_W'(SIZE_MAX));
  assign enq_ready_o = !full && (enq_qbar_i || !sat[enq_tag_i]);
  assign enq_fire    = enq_valid_i && enq_ready_o;
  assign push        = enq_fire && (enq_qbar_i || size_ok);
  assign enq_inc     = push && !enq_qbar_i;

  assign new_cmd = '{qbar: enq_qbar_i, dir: enq_dir_i, tag: enq_tag_i, size: enq_size_i,
                     fence: enq_fence_i, barrier: enq_barrier_i};

  assign iss_fire = iss_valid_o && iss_ready_i;
  assign pop      = iss_fire || retire;
  assign pop_idx  = retire ? '0 : sel_idx;

  dma_ord_queue #(.DEPTH(DEPTH)) u_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .push_cmd_i (new_cmd),
    .pop_i      (pop),
    .pop_idx_i  (pop_idx),
    .ent_o      (ent),
    .count_o    (count),
    .full_o     (full)
  );

  dma_ord_select #(.DEPTH(DEPTH)) u_select (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ent_i      (ent),
    .count_i    (count),
    .fly_zero_i (fly_zero),
    .valid_o    (iss_valid_o),
    .idx_o      (sel_idx),
    .retire_o   (retire)
  );

  dma_ord_tags #(.OUT_W(OUT_W)) u_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enq_inc_i   (enq_inc),
    .enq_tag_i   (enq_tag_i),
    .iss_inc_i   (iss_fire),
    .iss_tag_i   (iss_tag_o),
    .cpl_valid_i (cpl_valid_i),
    .cpl_tag_i   (cpl_tag_i),
    .busy_o      (tag_busy_o),
    .fly_zero_o  (fly_zero),
    .sat_o       (sat),
    .cpl_bad_o   (cpl_bad)
  );

  assign iss_dir_o  = ent[sel_idx].dir;
  assign iss_tag_o  = ent[sel_idx].tag;
  assign iss_size_o = ent[sel_idx].size;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_err_q <= 1'b0;
      cpl_err_q  <= 1'b0;
    end else begin
      if (enq_fire && !enq_qbar_i && !size_ok) size_err_q <= 1'b1;
      if (cpl_bad) cpl_err_q <= 1'b1;
    end
  end
  assign size_err_o = size_err_q;
  assign cpl_err_o  = cpl_err_q;

  assert_hold_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && !iss_ready_i) |=> iss_valid_o);
  assert_fence_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_fire && (ent[sel_idx].fence || ent[sel_idx].barrier)) |-> fly_zero[iss_tag_o]);
  assert_busy_on_offer_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o |-> tag_busy_o[iss_tag_o]);
  assert_legal_offer_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o |-> ((iss_size_o[GRAN_W-1:0] == '0) && (iss_size_o != '0) &&
                     (iss_size_o <= SIZE_W'(SIZE_MAX))));
  assert_size_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_err_o |=> size_err_o);
  assert_cpl_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_err_o |=> cpl_err_o);
endmodule

// File: tb/dma_cmd_order_test.sv
module dma_cmd_order_test;
  localparam int DEPTH   = 16;
  localparam int OUT_MAX = 63;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_ni = 1'b0;
  logic        enq_valid = 0, enq_qbar = 0, enq_dir = 0, enq_fence = 0, enq_barrier = 0;
  logic [4:0]  enq_tag = '0;
  logic [14:0] enq_size = '0;
  logic        iss_ready = 0, cpl_valid = 0;
  logic [4:0]  cpl_tag = '0;
  logic        enq_ready, iss_valid, iss_dir, size_err, cpl_err;
  logic [4:0]  iss_tag;
  logic [14:0] iss_size;
  logic [31:0] tag_busy;

  dma_cmd_order uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .enq_valid_i(enq_valid), .enq_ready_o(enq_ready), .enq_qbar_i(enq_qbar),
    .enq_dir_i(enq_dir), .enq_tag_i(enq_tag), .enq_size_i(enq_size),
    .enq_fence_i(enq_fence), .enq_barrier_i(enq_barrier),
    .iss_valid_o(iss_valid), .iss_ready_i(iss_ready), .iss_dir_o(iss_dir),
    .iss_tag_o(iss_tag), .iss_size_o(iss_size),
    .cpl_valid_i(cpl_valid), .cpl_tag_i(cpl_tag),
    .tag_busy_o(tag_busy), .size_err_o(size_err), .cpl_err_o(cpl_err)
  );

  typedef struct { bit qbar; bit dir; int tag; int size; bit fence; bit bar; } ment_t;
  ment_t mq[$];
  int    fly [32];
  int    outc [32];
  bit    m_serr, m_cerr;
  int    checks = 0, fails = 0, cyc = 0;
  bit    done = 0;

  task automatic chk(bit ok, string msg, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  function automatic bit legal(int s);
    return s > 0 && s % 16 == 0 && s <= 16384;
  endfunction

  function automatic bit m_ready();
    return mq.size() < DEPTH && (enq_qbar || outc[enq_tag] != OUT_MAX);
  endfunction

  function automatic void m_eval(output bit v, output int sel, output bit ret);
    bit blk, same;
    v = 0; sel = 0; ret = 0;
    if (mq.size() > 0 && mq[0].qbar) begin
      ret = 1;
      for (int g = 0; g < 32; g++) if (fly[g] != 0) ret = 0;
    end
    for (int i = 0; i < mq.size(); i++) begin
      if (!mq[i].qbar) begin
        blk = 0; same = 0;
        for (int j = 0; j < i; j++) begin
          if (mq[j].qbar) blk = 1;
          else if (mq[j].tag == mq[i].tag) begin
            same = 1;
            if (mq[j].bar) blk = 1;
          end
        end
        if ((mq[i].fence || mq[i].bar) && (same || fly[mq[i].tag] != 0)) blk = 1;
        if (!blk && !v) begin v = 1; sel = i; end
      end
    end
  endfunction

  // Reference model step
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mq.delete();
      for (int g = 0; g < 32; g++) begin fly[g] = 0; outc[g] = 0; end
      m_serr = 0; m_cerr = 0;
    end else begin
      bit v, ret, rdy, fire, acc, cok, ok_sz;
      int sel;
      ment_t e;
      m_eval(v, sel, ret);
      rdy   = m_ready();
      fire  = v && iss_ready;
      acc   = enq_valid && rdy;
      cok   = cpl_valid && fly[cpl_tag] > 0;
      ok_sz = legal(int'(enq_size));
      if (cpl_valid && !cok) m_cerr = 1;
      if (acc && !enq_qbar && !ok_sz) m_serr = 1;
      if (fire) begin
        fly[mq[sel].tag]++;
        mq.delete(sel);
      end else if (ret) mq.delete(0);
      if (cok) begin fly[cpl_tag]--; outc[cpl_tag]--; end
      if (acc && (enq_qbar || ok_sz)) begin
        e.qbar = enq_qbar; e.dir = enq_dir; e.tag = int'(enq_tag);
        e.size = int'(enq_size); e.fence = enq_fence; e.bar = enq_barrier;
        mq.push_back(e);
        if (!enq_qbar) outc[enq_tag]++;
      end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      bit v, ret;
      int sel;
      logic [31:0] mb;
      #2;
      m_eval(v, sel, ret);
      chk(iss_valid == v, "R3 iss_valid", iss_valid, v);
      if (v && iss_valid) begin
        chk(iss_tag == 5'(mq[sel].tag), "R3 iss_tag", iss_tag, mq[sel].tag);
        chk(iss_dir == mq[sel].dir, "R3 iss_dir", iss_dir, mq[sel].dir);
        chk(iss_size == 15'(mq[sel].size), "R3 iss_size", iss_size, mq[sel].size);
      end
      chk(enq_ready == m_ready(), "R1 enq_ready", enq_ready, m_ready());
      for (int g = 0; g < 32; g++) mb[g] = (outc[g] != 0);
      chk(tag_busy == mb, "R9 tag_busy", tag_busy, mb);
      chk(size_err == m_serr, "R2 size_err", size_err, m_serr);
      chk(cpl_err == m_cerr, "R10 cpl_err", cpl_err, m_cerr);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_up();
    end
  end

  task automatic tick();
    @(negedge clk);
    #3;
  endtask

  task automatic enq(bit qb, bit d, int t, int s, bit f, bit b);
    enq_valid = 1; enq_qbar = qb; enq_dir = d; enq_tag = 5'(t);
    enq_size = 15'(s); enq_fence = f; enq_barrier = b;
    tick();
    enq_valid = 0; enq_qbar = 0; enq_dir = 0; enq_tag = '0;
    enq_size = '0; enq_fence = 0; enq_barrier = 0;
  endtask

  task automatic take();
    iss_ready = 1; tick(); iss_ready = 0;
  endtask

  task automatic cpl(int t);
    cpl_valid = 1; cpl_tag = 5'(t); tick(); cpl_valid = 0; cpl_tag = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    tick();
    // R11 reset state
    chk(iss_valid == 0, "R11 iss_valid after reset", iss_valid, 0);
    chk(tag_busy == 0, "R11 tag_busy after reset", tag_busy, 0);
    chk(enq_ready == 1, "R11 enq_ready after reset", enq_ready, 1);
    chk(size_err == 0 && cpl_err == 0, "R11 error flags after reset", size_err | cpl_err, 0);

    // R3 pass-through, back-to-back issue
    iss_ready = 1;
    enq(0, 0, 3, 64, 0, 0);
    chk(iss_valid && iss_tag == 3 && iss_dir == 0, "R3 first get offered", iss_tag, 3);
    enq(0, 1, 4, 128, 0, 0);
    chk(iss_dir == 1 && iss_size == 128, "R3 put offered", iss_size, 128);
    tick();
    iss_ready = 0;
    chk(iss_valid == 0, "R4 queue drained without completions", iss_valid, 0);
    cpl(3); cpl(4);

    // R2 size legality
    enq(0, 0, 2, 16, 0, 0);
    enq(0, 0, 2, 16384, 0, 0);
    chk(tag_busy[2] == 1 && size_err == 0, "R2 legal extremes accepted", size_err, 0);
    enq(0, 0, 6, 0, 0, 0);
    enq(0, 0, 6, 8, 0, 0);
    enq(0, 0, 6, 16400, 0, 0);
    enq(0, 0, 6, 40, 0, 0);
    chk(size_err == 1, "R2 illegal size flag", size_err, 1);
    chk(tag_busy[6] == 0, "R2 illegal sizes not queued", tag_busy[6], 0);
    take(); take();
    chk(iss_valid == 0, "R2 only legal entries were queued", iss_valid, 0);
    cpl(2); cpl(2);
    chk(tag_busy[2] == 0, "R9 busy clears after completions", tag_busy[2], 0);

    // R5 fence
    enq(0, 0, 5, 32, 0, 0);
    take();
    enq(0, 0, 5, 48, 1, 0);
    chk(iss_valid == 0, "R5 fence waits for in-flight", iss_valid, 0);
    enq(0, 0, 5, 64, 0, 0);
    chk(iss_valid && iss_size == 64, "R5 younger passes fence", iss_size, 64);
    take();
    cpl(5);
    chk(iss_valid == 0, "R5 fence waits for last in-flight", iss_valid, 0);
    cpl(5);
    chk(iss_valid && iss_size == 48, "R5 fence released", iss_size, 48);
    take(); cpl(5);

    // R6 barrier
    enq(0, 0, 7, 16, 0, 0);
    take();
    enq(0, 0, 7, 32, 0, 1);
    enq(0, 0, 7, 48, 0, 0);
    enq(0, 1, 8, 80, 0, 0);
    chk(iss_valid && iss_tag == 8 && iss_size == 80, "R6 other group unaffected", iss_tag, 8);
    take();
    chk(iss_valid == 0, "R6 younger held behind barrier", iss_valid, 0);
    cpl(7);
    chk(iss_valid && iss_size == 32, "R6 barrier released", iss_size, 32);
    take();
    chk(iss_valid && iss_size == 48, "R6 younger released after barrier", iss_size, 48);
    take(); cpl(7); cpl(7); cpl(8);
    chk(tag_busy == 0, "R9 all groups idle", tag_busy, 0);

    // R7 drain marker
    enq(0, 0, 9, 16, 0, 0);
    take();
    enq(1, 0, 0, 0, 0, 0);
    enq(0, 0, 10, 32, 0, 0);
    chk(iss_valid == 0, "R7 younger held by drain marker", iss_valid, 0);
    cpl(9);
    chk(iss_valid == 0, "R7 marker retires one cycle later", iss_valid, 0);
    tick();
    chk(iss_valid && iss_tag == 10, "R7 released after drain", iss_tag, 10);
    take(); cpl(10);

    // R10 unmatched completion
    chk(cpl_err == 0, "R10 no error yet", cpl_err, 0);
    cpl(20);
    chk(cpl_err == 1 && tag_busy[20] == 0, "R10 unmatched completion flagged", cpl_err, 1);

    // R1 full queue, R3 oldest first
    for (int i = 0; i < DEPTH; i++) enq(0, 0, i, (i + 1) * 16, 0, 0);
    chk(enq_ready == 0, "R1 ready low when full", enq_ready, 0);
    enq(0, 0, 30, 16, 0, 0);
    chk(tag_busy[30] == 0, "R1 command refused when full", tag_busy[30], 0);
    iss_ready = 1;
    for (int i = 0; i < DEPTH; i++) begin
      chk(iss_size == 15'((i + 1) * 16), "R3 oldest issued first", iss_size, (i + 1) * 16);
      tick();
    end
    iss_ready = 0;
    for (int i = 0; i < DEPTH; i++) cpl(i);
    chk(tag_busy == 0, "R9 idle after drain", tag_busy, 0);

    // Random mix over few groups
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom % 100);
      enq_valid   = ($urandom % 2) == 1;
      enq_qbar    = ($urandom % 40) == 0;
      enq_dir     = ($urandom % 2) == 1;
      enq_tag     = 5'($urandom % 4);
      enq_size    = (r < 90) ? 15'((($urandom % 1024) + 1) * 16) : 15'($urandom % 17000);
      enq_fence   = ($urandom % 4) == 0;
      enq_barrier = ($urandom % 8) == 0;
      iss_ready   = ($urandom % 2) == 1;
      cpl_valid   = ($urandom % 3) == 0;
      cpl_tag     = 5'($urandom % 4);
      tick();
    end
    enq_valid = 0; enq_qbar = 0; iss_ready = 0; cpl_valid = 0;
    repeat (5) tick();
    finish_up();
  end
endmodule